// File: doc/BRIEF.md
# Serialized IRQ slave frame generator

This block is the peripheral end of a serialized interrupt line: a single shared open-drain wire that carries many interrupt requests by time slot. The line runs on the bus clock. A cycle opens with a long low start pulse. A series of data frames follows, one frame for each interrupt number. Each frame is three clocks long: a sample clock, a recovery clock and a turnaround clock. A stop pulse closes the cycle, and its length selects how the next cycle may begin.

The block counts consecutive low clocks on the sampled line to find the start pulse. It snapshots the pending interrupt vector and the channel-check request at that point. It then steps through the frames by counting clocks. In the sample clock of every frame whose request was captured, it pulls the line low. In the next clock it drives the line high, and at turnaround it releases the line. After the last frame it measures the stop pulse to learn the mode. In quiet mode it may open a cycle by itself with a single low clock. Two guards return it to idle: a high-time watchdog, and a check for a low level where none is allowed. The pad is outside the block, which provides only a drive value and an enable.

Top module: `sirq_slave`

## Requirements
- R1: During and after reset the output enable is 0 and the drive value is 1. The mode after reset is continuous, so no cycle is started by the block.
- R2: A low run of START_MIN to START_MAX clocks (4 to 8 by default), followed by a high clock, is taken as a start frame. Runs of 3 or of 9 or more clocks are not, and no frame is driven after them.
- R3: Number the first high clock after the start low as clock 1 (start recovery) and clock 2 as start turnaround. The sample clock of frame k is then clock 3k+3. Frames 0 to 15 carry IRQ0 to IRQ15, and frame 16 carries the channel-check request.
- R4: For a captured request, the block drives 0 with enable 1 in the sample clock and drives 1 with enable 1 in the recovery clock. The enable is 0 in the turnaround clock. Frames without a captured request are never driven.
- R5: The request vector is captured on the clock edge that recognises the start frame, which is the edge that samples clock 1. A change made before that edge is reported in this cycle. A change made after it waits for the next cycle.
- R6: After the last frame, a low stop pulse of exactly 2 clocks selects quiet mode and one of exactly 3 clocks selects continuous mode.
- R7: In quiet mode, the block drives a single low clock (enable 1, value 0) when it is idle, the line is high and any request is pending. In continuous mode it never does this.
- R8: A low line in a recovery or turnaround clock abandons the cycle. No later frame of that cycle is driven, and that low clock counts as the first clock of a new start frame.
- R9: After WDOG_LIM consecutive high clocks (96 by default) during an open cycle or the wait for the stop pulse, the block returns to idle. It therefore reaches its first quiet-mode self-start on clock WDOG_LIM+3 of a cycle that had no stop pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pend | input | 16 | Pending interrupt requests, bit n for IRQn |
| iochck_req | input | 1 | Pending channel-check request (frame 16) |
| line_in | input | 1 | Sampled level of the shared line |
| line_out | output | 1 | Value to drive onto the line |
| line_oe | output | 1 | Drive enable for the line |

## Verification
Two events can land on the same clock edge: the edge that recognises the start frame, and a change to the request inputs, since that edge is also the capture point. The bench changes the vector once in the start-recovery clock and once in the start-turnaround clock. It judges each change by the cycle in which the new frame is driven, this cycle for the first and the next cycle for the second. A second overlap occurs where the watchdog's return to idle meets a pending quiet-mode request. The bench holds the line high after the frames with no stop pulse and requires the self-start low on exactly clock WDOG_LIM+3.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SLVST  = 3'd1,
        ST_STA_TA = 3'd2,
        ST_FRAME  = 3'd3,
        ST_STOP   = 3'd4
    } sirq_st_e;

    localparam logic [1:0] PH_SAMPLE = 2'd0;
    localparam logic [1:0] PH_RECOV  = 2'd1;
    localparam logic [1:0] PH_TURN   = 2'd2;

endpackage

// File: rtl/sirq_run_cnt.sv
module sirq_run_cnt #(
    parameter int MAXV = 9,
    localparam int W = $clog2(MAXV + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hit_i,
    output logic [W-1:0] run_o
);
    localparam logic [W-1:0] MAX_C = W'(MAXV);

    logic [W-1:0] run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (!hit_i) begin
            run_d = '0;
        end else if (run_q != MAX_C) begin
            run_d = run_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    assign run_o = run_q;
endmodule

// File: rtl/sirq_slot_drive.sv
module sirq_slot_drive #(
    parameter int NSLOT = 17,
    localparam int SLW = $clog2(NSLOT)
) (
    input  logic             is_frame,
    input  logic             slv_drive,
    input  logic [SLW-1:0]   slot,
    input  logic [1:0]       phase,
    input  logic [NSLOT-1:0] lat,
    output logic             oe,
    output logic             dout
);
    import sirq_pkg::*;

    logic hit;

    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < NSLOT; i++) begin
            if (slot == SLW'(i)) hit = lat[i];
        end
    end

    always_comb begin
        oe   = 1'b0;
        dout = 1'b1;
        if (slv_drive) begin
            oe   = 1'b1;
            dout = 1'b0;
        end else if (is_frame && hit && phase != PH_TURN) begin
            oe   = 1'b1;
            dout = (phase == PH_RECOV);
        end
    end
endmodule

// File: rtl/sirq_slave.sv
module sirq_slave #(
    parameter int NIRQ      = 16,
    parameter int START_MIN = 4,
    parameter int START_MAX = 8,
    parameter int WDOG_LIM  = 96
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NIRQ-1:0] irq_pend,
    input  logic            iochck_req,
    input  logic            line_in,
    output logic            line_out,
    output logic            line_oe
);
    import sirq_pkg::*;

    localparam int NSLOT = NIRQ + 1;
    localparam int SLW   = $clog2(NSLOT);
    localparam int LCW   = $clog2(START_MAX + 2);
    localparam int WDW   = $clog2(WDOG_LIM + 1);

    localparam logic [LCW-1:0] SMIN_C = LCW'(START_MIN);
    localparam logic [LCW-1:0] SMAX_C = LCW'(START_MAX);
    localparam logic [LCW-1:0] QUIET_C = LCW'(2);
    localparam logic [LCW-1:0] CONT_C  = LCW'(3);
    localparam logic [WDW-1:0] WD_C   = WDW'(WDOG_LIM);
    localparam logic [SLW-1:0] LAST_C = SLW'(NSLOT - 1);

    typedef struct packed {
        sirq_st_e         st;
        logic [SLW-1:0]   slot;
        logic [1:0]       phase;
        logic [NSLOT-1:0] lat;
        logic             quiet;
    } sirq_regs_t;

    localparam sirq_regs_t RST_C = '{
        st: ST_IDLE, slot: '0, phase: PH_SAMPLE, lat: '0, quiet: 1'b0
    };

    sirq_regs_t d, q;

    logic [LCW-1:0] low_run;
    logic [WDW-1:0] high_run;
    logic in_frame, in_stop, ph_zero, wd_hit, quiet_mode, any_req, start_ok;

    sirq_run_cnt #(.MAXV(START_MAX + 1)) u_low_run (
        .clk   (clk),
        .rst_n (rst_n),
        .hit_i (!line_in),
        .run_o (low_run)
    );

    sirq_run_cnt #(.MAXV(WDOG_LIM)) u_high_run (
        .clk   (clk),
        .rst_n (rst_n),
        .hit_i (line_in),
        .run_o (high_run)
    );

    assign in_frame   = (q.st == ST_FRAME);
    assign in_stop    = (q.st == ST_STOP);
    assign ph_zero    = (q.phase == PH_SAMPLE);
    assign wd_hit     = (high_run >= WD_C);
    assign quiet_mode = q.quiet;
    assign any_req    = (|irq_pend) || iochck_req;
    assign start_ok   = line_in && (low_run >= SMIN_C) && (low_run <= SMAX_C);

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (start_ok) begin
                    d.st  = ST_STA_TA;
                    d.lat = {iochck_req, irq_pend};
                end else if (line_in && q.quiet && any_req) begin
                    d.st = ST_SLVST;
                end
            end
            ST_SLVST: begin
                d.st = ST_IDLE;
            end
            ST_STA_TA: begin
                if (!line_in || wd_hit) begin
                    d.st = ST_IDLE;
                end else begin
                    d.st    = ST_FRAME;
                    d.slot  = '0;
                    d.phase = PH_SAMPLE;
                end
            end
            ST_FRAME: begin
                if (!line_in && !ph_zero) begin
                    d.st = ST_IDLE;
                end else if (line_in && wd_hit) begin
                    d.st = ST_IDLE;
                end else if (q.phase == PH_TURN) begin
                    d.phase = PH_SAMPLE;
                    if (q.slot == LAST_C) begin
                        d.st = ST_STOP;
                    end else begin
                        d.slot = q.slot + 1'b1;
                    end
                end else begin
                    d.phase = q.phase + 1'b1;
                end
            end
            ST_STOP: begin
                if (line_in) begin
                    if (low_run != '0) begin
                        d.st = ST_IDLE;
                        if (low_run == QUIET_C)     d.quiet = 1'b1;
                        else if (low_run == CONT_C) d.quiet = 1'b0;
                    end else if (wd_hit) begin
                        d.st = ST_IDLE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_C;
        else        q <= d;
    end

    sirq_slot_drive #(.NSLOT(NSLOT)) u_drive (
        .is_frame  (in_frame),
        .slv_drive (q.st == ST_SLVST),
        .slot      (q.slot),
        .phase     (q.phase),
        .lat       (q.lat),
        .oe        (line_oe),
        .dout      (line_out)
    );
endmodule

// File: rtl/sirq_slave_chk.sv
module sirq_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic line_in,
    input logic line_oe,
    input logic line_out,
    input logic in_frame,
    input logic in_stop,
    input logic ph_zero,
    input logic wd_hit,
    input logic quiet_mode
);
    // R4
    low_then_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe && !line_out && in_frame) |=> (line_oe && line_out));

    // R4
    release_after_recov_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe && line_out) |=> !line_oe);

    // R7
    self_start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe && !in_frame) |-> quiet_mode);

    // R8
    bad_low_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame && !ph_zero && !line_in) |=> (!in_frame && !in_stop));

    // R9
    stop_wdog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stop && line_in && wd_hit) |=> !in_stop);
endmodule

bind sirq_slave sirq_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_in    (line_in),
    .line_oe    (line_oe),
    .line_out   (line_out),
    .in_frame   (in_frame),
    .in_stop    (in_stop),
    .ph_zero    (ph_zero),
    .wd_hit     (wd_hit),
    .quiet_mode (quiet_mode)
);

// File: tb/sirq_slave_bench.sv
`timescale 1ns/1ps
module sirq_slave_bench;
    localparam int WDOG_LIM = 96;

    typedef struct {
        logic oe;
        logic dout;
        int   rq;
        int   idx;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [16:0] pend = '0;
    logic        host_low = 1'b0;
    logic        line_w, line_out, line_oe;
    int          checks = 0;
    int          fails = 0;
    bit          done = 0;
    exp_t        sb_q[$];

    always #10 clk = ~clk;

    assign line_w = host_low ? 1'b0 : (line_oe ? line_out : 1'b1);

    sirq_slave u_sirq_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_pend   (pend[15:0]),
        .iochck_req (pend[16]),
        .line_in    (line_w),
        .line_out   (line_out),
        .line_oe    (line_oe)
    );

    task automatic report();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // monitor: pops one expected item per clock pushed by the driver
    initial forever begin
        @(negedge clk);
        #2;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (line_oe !== e.oe || line_out !== e.dout) begin
                fails++;
                $display("FAIL R%0d clock %0d: oe/out=%b/%b expected %b/%b",
                         e.rq, e.idx, line_oe, line_out, e.oe, e.dout);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete");
        report();
    end

    task automatic tick(input logic hl, input logic eo, input logic ed,
                        input int rq, input int idx);
        @(negedge clk);
        host_low = hl;
        sb_q.push_back('{eo, ed, rq, idx});
    endtask

    // R2: start low run; sf marks a self-started first clock (R7)
    task automatic start_low(input int n, input logic sf);
        for (int j = 0; j < n; j++) begin
            logic own;
            own = sf && (j == 0);
            tick(1'b1, own, !own, own ? 7 : 2, j);
        end
    endtask

    // R3 / R4 / R5: start recovery, turnaround and the 17 frames
    task automatic frames(input logic [16:0] lat, input int cut,
                          input int chg_at, input logic [16:0] chg_val);
        for (int k = 1; k <= 53 && k < cut; k++) begin
            logic eo, ed;
            int   rq, f, ph;
            eo = 1'b0; ed = 1'b1; rq = 2;
            if (k >= 3) begin
                f  = (k - 3) / 3;
                ph = (k - 3) % 3;
                rq = 3;
                if (lat[f]) begin
                    rq = 4;
                    if (ph == 0) begin eo = 1'b1; ed = 1'b0; end
                    else if (ph == 1) begin eo = 1'b1; ed = 1'b1; end
                end
            end
            tick(1'b0, eo, ed, rq, k);
            if (k == chg_at) pend = chg_val;
        end
    endtask

    // R6: stop pulse then one high clock
    task automatic stop_pulse(input int n);
        for (int j = 0; j < n; j++) tick(1'b1, 1'b0, 1'b1, 6, j);
        tick(1'b0, 1'b0, 1'b1, 6, n);
    endtask

    task automatic idle(input int n, input int rq);
        for (int j = 0; j < n; j++) tick(1'b0, 1'b0, 1'b1, rq, j);
    endtask

    initial begin
        // R1: values held in reset
        repeat (3) @(negedge clk);
        checks++;
        if (line_oe !== 1'b0 || line_out !== 1'b1) begin
            fails++;
            $display("FAIL R1 in reset: oe/out=%b/%b expected 0/1", line_oe, line_out);
        end
        rst_n = 1'b1;
        idle(3, 1);

        // R7 / R1: continuous after reset, pending requests start nothing
        pend = 17'h1_8021;
        idle(5, 7);
        // R2 / R3 / R4: 4-clock start, IRQ0, IRQ5, IRQ15 and the check frame
        start_low(4, 1'b0);
        frames(17'h1_8021, 99, 0, '0);
        stop_pulse(3);

        // R5: change in start recovery clock is captured
        pend = 17'h0_0002;
        start_low(8, 1'b0);
        frames(17'h0_4002, 99, 1, 17'h0_4002);
        stop_pulse(3);
        // R5: change in start turnaround clock waits a cycle
        start_low(5, 1'b0);
        frames(17'h0_4002, 99, 2, 17'h0_0004);
        stop_pulse(3);
        start_low(6, 1'b0);
        frames(17'h0_0004, 99, 0, '0);
        stop_pulse(3);

        // R2: runs of 3 and of 9 low clocks are not a start
        start_low(3, 1'b0);
        frames('0, 99, 0, '0);
        start_low(9, 1'b0);
        frames('0, 99, 0, '0);

        // R8: low in frame 2 recovery abandons the cycle, restarts detection
        pend = 17'h0_0401;
        start_low(4, 1'b0);
        frames(17'h0_0401, 10, 0, '0);
        for (int j = 10; j < 15; j++) tick(1'b1, 1'b0, 1'b1, 8, j);
        frames(17'h0_0401, 99, 0, '0);
        stop_pulse(3);

        // R6: 2-clock stop selects quiet mode
        pend = '0;
        start_low(4, 1'b0);
        frames('0, 99, 0, '0);
        stop_pulse(2);
        idle(3, 7);
        // R7: quiet-mode self start with IRQ3 pending
        tick(1'b0, 1'b0, 1'b1, 7, 0);
        pend = 17'h0_0008;
        start_low(4, 1'b1);
        frames(17'h0_0008, 99, 2, '0);
        stop_pulse(2);

        // R9: no stop pulse; watchdog returns to idle, then quiet self start
        start_low(4, 1'b0);
        frames('0, 99, 0, '0);
        for (int k = 54; k <= WDOG_LIM + 2; k++) begin
            tick(1'b0, 1'b0, 1'b1, 9, k);
            if (k == 54) pend = 17'h0_0080;
        end
        tick(1'b1, 1'b1, 1'b0, 9, WDOG_LIM + 3);
        start_low(3, 1'b0);
        frames(17'h0_0080, 99, 2, '0);
        // R6: 3-clock stop returns to continuous mode
        stop_pulse(3);
        pend = 17'h0_0010;
        idle(6, 6);
        pend = '0;
        idle(2, 1);

        repeat (2) @(negedge clk);
        report();
    end
endmodule